// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

The block receives asynchronous serial frames on an idle-high line. After a two-stage synchronizer it waits for a falling edge and checks the start bit at mid-bit. It then samples each later bit at its centre, using a 16x oversampling tick, and shifts the bits into a shift register. Each frame has one start bit at 0 and eight data bits, least significant first. An optional parity bit follows, then one stop bit at 1. A finished frame is checked for parity and stop-bit errors before it is passed to a receive data register.

Four sticky flags report the result: data ready, overrun, parity error and framing error. Each error type has its own rule for whether the byte is transferred. On any error, data ready keeps the value it had before the frame. While any error flag is set, no new frame starts. Two level interrupt outputs report the flags, and both are gated by a receive interrupt enable. Software clears flags with a write-0-to-clear strobe. The baud tick comes from outside the block.

Top module: `serial_rx_flagged`

## Requirements
- R1: After reset rdata_o is 0x00, all four flags are 0 and both interrupt outputs are 0.
- R2: A frame with no error writes its eight data bits to rdata_o. The first data bit after the start bit is bit 0. The frame also sets ready_o.
- R3: When par_en_i is 1, a parity bit follows the data. With par_odd_i=0 the data bits and the parity bit together hold an even number of ones, and with par_odd_i=1 an odd number. A mismatch sets perr_o and still writes the byte to rdata_o, while ready_o keeps its earlier value.
- R4: A stop bit sampled as 0 sets ferr_o and still writes the byte to rdata_o, while ready_o keeps its earlier value.
- R5: A frame that completes while ready_o is 1 sets ovr_o. rdata_o keeps its old byte and ready_o stays 1.
- R6: While ovr_o, perr_o or ferr_o is 1, an incoming frame is ignored: rdata_o and ready_o do not change.
- R7: A low pulse on the line that has returned high by the middle of the start bit is treated as noise. No frame is taken, and a following frame is received normally.
- R8: When clr_we_i is 1, each flag whose bit in clr_data_i is 0 is cleared and each flag whose bit is 1 is kept. The bit positions are [0] ready, [1] overrun, [2] parity error and [3] framing error. Clearing does not change rdata_o.
- R9: rx_irq_o equals rie_i AND ready_o. err_irq_o equals rie_i AND (ovr_o OR perr_o OR ferr_o).
- R10: When par_en_i is 0 the frame has no parity bit, so the stop bit directly follows data bit 7, and perr_o is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| os_tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| rie_i | input | 1 | Receive interrupt enable |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_data_i | input | 4 | Write-0-to-clear mask: [0] ready, [1] ovr, [2] perr, [3] ferr |
| rdata_o | output | 8 | Receive data register |
| ready_o | output | 1 | Data ready flag |
| ovr_o | output | 1 | Overrun flag |
| perr_o | output | 1 | Parity error flag |
| ferr_o | output | 1 | Framing error flag |
| rx_irq_o | output | 1 | Receive-complete interrupt |
| err_irq_o | output | 1 | Receive error interrupt |

## Verification
The bench sends a second frame while ready_o is still 1. A design that overwrote the register on overrun would show the new byte instead of the old one. Frames sent while an error flag is set must leave rdata_o alone, so a receiver that ignored the block would take them. Parity and framing errors must still deliver the byte while ready_o stays low; swapped transfer rules would show up in rdata_o or ready_o. The bench also sends a short start glitch, a partial clear mask and frames with interrupts disabled, which catch a receiver that accepts unconfirmed starts, a clear decoded at the wrong bit and interrupts that are not gated.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  localparam int unsigned FLG_RDY = 0;
  localparam int unsigned FLG_OVR = 1;
  localparam int unsigned FLG_PER = 2;
  localparam int unsigned FLG_FER = 3;
  localparam int unsigned FLG_W   = 4;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr <= '1;
    else         sr <= {sr[STAGES-2:0], d_i};
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OS_RATE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              block_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);
  import serial_rx_pkg::*;

  localparam int unsigned CNT_W = $clog2(OS_RATE);
  localparam int unsigned BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OS_RATE/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OS_RATE - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  rx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bits;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic              at_centre;

  assign at_centre = (cnt == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      bits   <= '0;
      shreg  <= '0;
      pbit   <= 1'b0;
      done_o <= 1'b0;
      data_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (st)
          ST_IDLE: begin
            if (!rx_i && !block_i) begin
              st  <= ST_START;
              cnt <= '0;
            end
          end
          ST_START: begin
            if (cnt == MID_CNT) begin
              cnt  <= '0;
              bits <= '0;
              st   <= rx_i ? ST_IDLE : ST_DATA;  // high at mid-bit: noise
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_centre) begin
              cnt   <= '0;
              shreg <= {rx_i, shreg[DATA_W-1:1]};
              bits  <= bits + 1'b1;
              if (bits == LAST_BIT) st <= par_en_i ? ST_PAR : ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_centre) begin
              cnt  <= '0;
              pbit <= rx_i;
              st   <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_centre) begin
              cnt    <= '0;
              st     <= ST_IDLE;
              done_o <= 1'b1;
              data_o <= shreg;
              perr_o <= par_en_i && ((^shreg ^ pbit) != par_odd_i);
              ferr_o <= !rx_i;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           done_i,
  input  logic [DATA_W-1:0]              data_i,
  input  logic                           perr_i,
  input  logic                           ferr_i,
  input  logic                           clr_we_i,
  input  logic [serial_rx_pkg::FLG_W-1:0] clr_data_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [serial_rx_pkg::FLG_W-1:0] flags_o
);
  import serial_rx_pkg::*;

  logic [FLG_W-1:0] set_v, keep_v;
  logic             ovr_evt, write_en;

  assign ovr_evt  = done_i && flags_o[FLG_RDY];
  assign write_en = done_i && !flags_o[FLG_RDY];

  always_comb begin
    set_v          = '0;
    set_v[FLG_OVR] = ovr_evt;
    set_v[FLG_PER] = write_en && perr_i;
    set_v[FLG_FER] = write_en && ferr_i;
    set_v[FLG_RDY] = write_en && !perr_i && !ferr_i;
    keep_v         = clr_we_i ? clr_data_i : '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      rdata_o <= '0;
    end else begin
      flags_o <= set_v | (flags_o & keep_v);  // set wins over clear
      if (write_en) rdata_o <= data_i;
    end
  end
endmodule

// File: rtl/serial_rx_flagged.sv
module serial_rx_flagged #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OS_RATE     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              os_tick_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rie_i,
  input  logic              clr_we_i,
  input  logic [3:0]        clr_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              ovr_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);
  import serial_rx_pkg::*;

  logic              rx_s, done, f_perr, f_ferr, blocked;
  logic [DATA_W-1:0] f_data;
  logic [FLG_W-1:0]  flags;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(rxd_i), .q_o(rx_s)
  );

  serial_rx_engine #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) i_engine (
    .clk_i, .rst_ni, .rx_i(rx_s), .tick_i(os_tick_i),
    .par_en_i, .par_odd_i, .block_i(blocked),
    .done_o(done), .data_o(f_data), .perr_o(f_perr), .ferr_o(f_ferr)
  );

  serial_rx_flags #(.DATA_W(DATA_W)) i_flags (
    .clk_i, .rst_ni, .done_i(done), .data_i(f_data),
    .perr_i(f_perr), .ferr_i(f_ferr),
    .clr_we_i, .clr_data_i, .rdata_o, .flags_o(flags)
  );

  assign blocked   = flags[FLG_OVR] | flags[FLG_PER] | flags[FLG_FER];
  assign ready_o   = flags[FLG_RDY];
  assign ovr_o     = flags[FLG_OVR];
  assign perr_o    = flags[FLG_PER];
  assign ferr_o    = flags[FLG_FER];
  assign rx_irq_o  = rie_i & ready_o;
  assign err_irq_o = rie_i & blocked;
endmodule

// File: rtl/serial_rx_flagged_chk.sv
module serial_rx_flagged_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              par_en_i,
  input logic              rie_i,
  input logic              clr_we_i,
  input logic [3:0]        clr_data_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              ready_o,
  input logic              ovr_o,
  input logic              perr_o,
  input logic              ferr_o,
  input logic              rx_irq_o,
  input logic              err_irq_o
);
  a_r5_ovr_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(ready_o));

  a_r5_ovr_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $stable(rdata_o));

  a_r2_ready_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (!perr_o && !ferr_o));

  a_r6_data_only_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> ($rose(ready_o) || $rose(perr_o) || $rose(ferr_o)));

  a_r8_ready_clear_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(clr_we_i && !clr_data_i[0]));

  a_r10_no_perr_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(perr_o) |-> par_en_i);

  a_r9_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rie_i |-> (!rx_irq_o && !err_irq_o));
endmodule

bind serial_rx_flagged serial_rx_flagged_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_serial_rx_flagged.sv
module test_serial_rx_flagged;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       rxd = 1'b1, tick = 1'b0, par_en = 1'b0, par_odd = 1'b0, rie = 1'b1;
  logic       clr_we = 1'b0;
  logic [3:0] clr_data = 4'hF;
  logic [7:0] rdata;
  logic       ready, ovr, perr, ferr, rx_irq, err_irq;

  int unsigned n_run = 0, n_fail = 0;
  bit          finished = 0;

  typedef struct {
    logic [7:0] data;
    logic [3:0] flg;   // {ferr, perr, ovr, ready}
    logic [1:0] irq;   // {err, rx}
    string      req;
  } exp_t;
  exp_t exp_q[$];
  event chk_ev;

  serial_rx_flagged i_serial_rx_flagged (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .os_tick_i(tick),
    .par_en_i(par_en), .par_odd_i(par_odd), .rie_i(rie),
    .clr_we_i(clr_we), .clr_data_i(clr_data), .rdata_o(rdata),
    .ready_o(ready), .ovr_o(ovr), .perr_o(perr), .ferr_o(ferr),
    .rx_irq_o(rx_irq), .err_irq_o(err_irq)
  );

  always #10 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic compare(exp_t e);
    n_run++;
    if (rdata !== e.data || {ferr, perr, ovr, ready} !== e.flg ||
        {err_irq, rx_irq} !== e.irq) begin
      n_fail++;
      $display("FAIL %s: data=%h flg=%b irq=%b expected data=%h flg=%b irq=%b",
               e.req, rdata, {ferr, perr, ovr, ready}, {err_irq, rx_irq},
               e.data, e.flg, e.irq);
    end
  endtask

  // monitor: pops expected items when the driver marks a result point
  initial begin
    forever begin
      @(chk_ev);
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL scoreboard: empty queue actual data=%h expected item", rdata);
      end else begin
        compare(exp_q.pop_front());
      end
    end
  end

  task automatic line_bit(input logic b);
    rxd = b;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic pb, input logic stp);
    line_bit(1'b0);
    for (int i = 0; i < 8; i++) line_bit(d[i]);
    if (par_en) line_bit(pb);
    line_bit(stp);
    line_bit(1'b1);
  endtask

  task automatic expect_now(input logic [7:0] d, input logic [3:0] f, input string r);
    exp_t e;
    e.data = d; e.flg = f;
    e.irq  = {rie & (|f[3:1]), rie & f[0]};
    e.req  = r;
    exp_q.push_back(e);
    -> chk_ev;
    @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] d, input logic pb, input logic stp,
                       input logic [7:0] ed, input logic [3:0] ef, input string r);
    send(d, pb, stp);
    expect_now(ed, ef, r);
  endtask

  task automatic clear(input logic [3:0] m);
    clr_data = m; clr_we = 1'b1;
    @(negedge clk);
    clr_we = 1'b0; clr_data = 4'hF;
    @(negedge clk);
  endtask

  function automatic logic good_par(input logic [7:0] d, input logic odd);
    return ^d ^ odd;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_now(8'h00, 4'b0000, "R1 reset");

    frame(8'hA5, 1'b0, 1'b1, 8'hA5, 4'b0001, "R2 R10 R9 clean frame no parity");
    frame(8'h3C, 1'b0, 1'b1, 8'hA5, 4'b0011, "R5 overrun keeps data");
    frame(8'h77, 1'b0, 1'b1, 8'hA5, 4'b0011, "R6 blocked frame ignored");
    clear(4'b1101);
    expect_now(8'hA5, 4'b0001, "R8 partial clear only ovr");
    clear(4'b0000);
    expect_now(8'hA5, 4'b0000, "R8 full clear keeps rdata");

    par_en = 1'b1; par_odd = 1'b0;
    frame(8'h5A, good_par(8'h5A, 1'b0), 1'b1, 8'h5A, 4'b0001, "R3 even parity ok");
    clear(4'b0000);
    par_odd = 1'b1;
    frame(8'h07, good_par(8'h07, 1'b1), 1'b1, 8'h07, 4'b0001, "R3 odd parity ok");
    clear(4'b0000);
    par_odd = 1'b0;
    frame(8'h81, ~good_par(8'h81, 1'b0), 1'b1, 8'h81, 4'b0100, "R3 parity error");
    frame(8'h66, good_par(8'h66, 1'b0), 1'b1, 8'h81, 4'b0100, "R6 blocked on perr");
    clear(4'b0000);

    par_en = 1'b0;
    frame(8'h42, 1'b0, 1'b0, 8'h42, 4'b1000, "R4 framing error");
    clear(4'b0000);
    expect_now(8'h42, 4'b0000, "R8 ferr cleared");

    rie = 1'b0;
    frame(8'h99, 1'b0, 1'b1, 8'h99, 4'b0001, "R9 irq masked");
    rie = 1'b1;
    expect_now(8'h99, 4'b0001, "R9 irq enabled");
    clear(4'b0000);

    rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (256) @(negedge clk);
    expect_now(8'h99, 4'b0000, "R7 glitch ignored");
    frame(8'h12, 1'b0, 1'b1, 8'h12, 4'b0001, "R7 frame after glitch");

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule